// File: doc/BRIEF.md
# Pulse Width Measurement Timer

This block is one channel of a timer that measures how long an input signal stays at a chosen level. Software selects whether the high or the low phase is measured and then pulses a start input. The channel then waits for the edge that opens the selected phase. It counts count-clock ticks until the edge that closes the phase. At the closing edge it stores the count in a capture register, records whether the counter wrapped, and raises a one-cycle interrupt. It then waits for the next opening edge by itself, with no further start pulse.

The input is asynchronous. It passes through a synchronizer of `SYNC_STAGES` flops on the system clock, and edges are found by comparing consecutive synchronized samples. Edges are therefore resolved to one system clock. The counter is loaded with zero on the opening edge, and that load counts as the first tick. The width in ticks is therefore 2^CNT_W × overflow + capture + 1. The overflow bit only says that at least one wrap happened, so a result is valid only when there was at most one wrap. A stop input returns the channel to idle and leaves the last result readable.

Top module: `pulse_width_timer`

## Requirements
- R1: After reset, enabled_o, capture_o, ovf_o, irq_o and count_o are all 0, and mode_o is 2'b11.
- R2: A start pulse while disabled sets enabled_o to 1 and arms the channel. count_o does not change until the opening edge arrives.
- R3: With mode 2'b11 and tick_i high every cycle, a high phase lasting W system clocks captures W-1 and reports ovf_o = 0 (for W below 65536).
- R4: With mode 2'b10 and tick_i high every cycle, a low phase lasting W system clocks captures W-1 and reports ovf_o = 0.
- R5: irq_o is high for exactly one cycle per measurement. It rises in the same cycle that capture_o takes the new value.
- R6: After a capture, count_o holds at capture_o + 1 while the channel waits. The next phase is measured without a new start pulse.
- R7: At each capture, ovf_o is set to 1 if the counter wrapped from all-ones to zero during that measurement and cleared to 0 otherwise. A phase of 66000 ticks captures 464 - 1 = 463 with ovf_o = 1.
- R8: A start pulse while enabled_o is 1 is ignored: a measurement in progress completes with its normal result.
- R9: stop_i clears enabled_o and idles the channel. capture_o and ovf_o keep their values, and input edges produce no interrupt until the next start.
- R10: The counter advances only in cycles where tick_i is 1. A phase with tick_i held low captures 0.
- R11: A mode write (mode_we_i) takes effect only while enabled_o is 0 and only if mode_wdata_i[1] is 1. Otherwise mode_o is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-clock enable, one cycle per tick |
| sig_i | input | 1 | Asynchronous signal to be measured |
| start_i | input | 1 | Start trigger pulse |
| stop_i | input | 1 | Stop pulse; has priority over start |
| mode_we_i | input | 1 | Mode write strobe |
| mode_wdata_i | input | 2 | Mode value: 2'b11 high phase, 2'b10 low phase |
| mode_o | output | 2 | Current mode |
| enabled_o | output | 1 | Channel enable state |
| count_o | output | CNT_W | Live counter value |
| capture_o | output | CNT_W | Last captured count |
| ovf_o | output | 1 | Wrap flag of the last measurement |
| irq_o | output | 1 | One-cycle capture interrupt |

## Verification
The assertions check on every cycle that the interrupt is never longer than one cycle and that the counter holds in cycles without a tick. They also check that the counter reads capture plus one right after a capture, and that the overflow bit moves only at a capture. Further cycle checks cover start being ignored while enabled, stop forcing idle, and the mode staying locked while enabled. Only the bench's scenarios can show the measured values themselves. These include exact widths for both levels, automatic re-arming across back-to-back phases, an overflow value, and the absence of interrupts while stopped.

// File: rtl/pwt_pkg.sv
package pwt_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_COUNT = 2'd2
   } pwt_state_e;

   localparam logic [1:0] MODE_LOW_PHASE  = 2'b10;
   localparam logic [1:0] MODE_HIGH_PHASE = 2'b11;

endpackage

// File: rtl/pwt_sync_edge.sv
module pwt_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o,
   output logic fall_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pwt_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o =  chain_q[STAGES-1] & ~prev_q;
   assign fall_o = ~chain_q[STAGES-1] &  prev_q;

endmodule

// File: rtl/pwt_ctrl.sv
module pwt_ctrl
   import pwt_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       start_i,
   input  logic       stop_i,
   input  logic       mode_we_i,
   input  logic [1:0] mode_wdata_i,
   input  logic       rise_i,
   input  logic       fall_i,
   output logic [1:0] mode_o,
   output logic       en_o,
   output logic       load_o,
   output logic       cap_o,
   output logic       count_en_o
);

   pwt_state_e state_q;
   logic       en_q;
   logic [1:0] mode_q;
   logic       open_edge, close_edge;

   // mode bit 0 selects the phase: 1 = high phase, 0 = low phase
   assign open_edge  = mode_q[0] ? rise_i : fall_i;
   assign close_edge = mode_q[0] ? fall_i : rise_i;

   assign load_o     = (state_q == ST_ARMED) && open_edge  && !stop_i;
   assign cap_o      = (state_q == ST_COUNT) && close_edge && !stop_i;
   assign count_en_o = (state_q == ST_COUNT);
   assign en_o       = en_q;
   assign mode_o     = mode_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         en_q    <= 1'b0;
         mode_q  <= MODE_HIGH_PHASE;
      end else begin
         if (mode_we_i && !en_q && mode_wdata_i[1]) begin
            mode_q <= mode_wdata_i;
         end
         if (stop_i) begin
            en_q    <= 1'b0;
            state_q <= ST_IDLE;
         end else if (start_i && !en_q) begin
            en_q    <= 1'b1;
            state_q <= ST_ARMED;
         end else begin
            unique case (state_q)
               ST_ARMED: if (open_edge)  state_q <= ST_COUNT;
               ST_COUNT: if (close_edge) state_q <= ST_ARMED;
               default:  state_q <= state_q;
            endcase
         end
      end
   end

   AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_q && start_i && !stop_i |=> en_q && state_q != ST_IDLE); // R8
   AST_STOP_IDLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stop_i |=> !en_q && state_q == ST_IDLE); // R9
   AST_MODE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_q |=> $stable(mode_q)); // R11
   AST_MODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_q[1]); // R11

endmodule

// File: rtl/pwt_counter.sv
module pwt_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             load_i,
   input  logic             cap_i,
   input  logic             count_en_i,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] capture_o,
   output logic             ovf_o,
   output logic             irq_o
);

   if (CNT_W < 2) begin : g_bad_width
      $error("pwt_counter: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q, capture_q;
   logic             wrap_q, ovf_q, irq_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q     <= '0;
         capture_q <= '0;
         wrap_q    <= 1'b0;
         ovf_q     <= 1'b0;
         irq_q     <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (load_i) begin
            cnt_q  <= '0;
            wrap_q <= 1'b0;
         end else if (cap_i) begin
            capture_q <= cnt_q;
            ovf_q     <= wrap_q;
            cnt_q     <= cnt_q + 1'b1;
            irq_q     <= 1'b1;
         end else if (count_en_i && tick_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_MAX) wrap_q <= 1'b1;
         end
      end
   end

   assign count_o   = cnt_q;
   assign capture_o = capture_q;
   assign ovf_o     = ovf_q;
   assign irq_o     = irq_q;

   AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_q |=> !irq_q); // R5
   AST_FREEZE_PLUS_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_i |=> cnt_q == CNT_W'(capture_q + 1'b1)); // R6
   AST_TICK_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i && !load_i && !cap_i |=> $stable(cnt_q)); // R10
   AST_OVF_AT_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cap_i |=> $stable(ovf_q) && $stable(capture_q)); // R7

endmodule

// File: rtl/pulse_width_timer.sv
module pulse_width_timer #(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             sig_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic             mode_we_i,
   input  logic [1:0]       mode_wdata_i,
   output logic [1:0]       mode_o,
   output logic             enabled_o,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] capture_o,
   output logic             ovf_o,
   output logic             irq_o
);

   logic rise, fall, load, cap, count_en;

   pwt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (sig_i),
      .rise_o  (rise),
      .fall_o  (fall)
   );

   pwt_ctrl u_ctrl (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .start_i      (start_i),
      .stop_i       (stop_i),
      .mode_we_i    (mode_we_i),
      .mode_wdata_i (mode_wdata_i),
      .rise_i       (rise),
      .fall_i       (fall),
      .mode_o       (mode_o),
      .en_o         (enabled_o),
      .load_o       (load),
      .cap_o        (cap),
      .count_en_o   (count_en)
   );

   pwt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick_i),
      .load_i     (load),
      .cap_i      (cap),
      .count_en_i (count_en),
      .count_o    (count_o),
      .capture_o  (capture_o),
      .ovf_o      (ovf_o),
      .irq_o      (irq_o)
   );

   AST_NO_IRQ_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enabled_o |=> !irq_o); // R9

endmodule

// File: tb/tb_pulse_width_timer.sv
module tb_pulse_width_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b1;
   logic        sig = 1'b0;
   logic        start = 1'b0;
   logic        stop = 1'b0;
   logic        mode_we = 1'b0;
   logic [1:0]  mode_wd = 2'b00;
   logic [1:0]  mode;
   logic        en;
   logic [15:0] count, capture;
   logic        ovf, irq;

   int n_checks = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   pulse_width_timer dut (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .sig_i(sig),
      .start_i(start), .stop_i(stop), .mode_we_i(mode_we),
      .mode_wdata_i(mode_wd), .mode_o(mode), .enabled_o(en),
      .count_o(count), .capture_o(capture), .ovf_o(ovf), .irq_o(irq)
   );

   // bit 16 = 1 for high phase, low 16 bits = width in clocks
   localparam logic [16:0] VEC [0:7] = '{
      17'h1_0004, 17'h1_0009, 17'h1_00FA, 17'h1_0001,
      17'h0_0003, 17'h0_0028, 17'h0_0309, 17'h0_0002
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   endtask

   task automatic pulse_start();
      start = 1'b1; @(negedge clk); start = 1'b0;
   endtask

   task automatic pulse_stop();
      stop = 1'b1; @(negedge clk); stop = 1'b0;
   endtask

   task automatic write_mode(input logic [1:0] v);
      mode_we = 1'b1; mode_wd = v; @(negedge clk); mode_we = 1'b0;
   endtask

   // Drives one phase of w clocks at level hi, then polls for the interrupt.
   task automatic phase(input bit hi, input int w, input int start_at,
                        output bit got, output int cap, output bit ov);
      got = 1'b0; cap = 0; ov = 1'b0;
      sig = hi;
      for (int i = 0; i < w; i++) begin
         if (i == start_at) start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      sig = ~hi;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (irq) begin
            got = 1'b1; cap = capture; ov = ovf;
            check(count == 16'(capture + 1), "R6 freeze", count, capture + 1);
            @(negedge clk);
            check(!irq, "R5 single pulse", irq, 0);
            break;
         end
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual 1 expected 0");
      finish_run();
   end

   initial begin
      bit got, ov;
      int cap;
      bit cur_hi;

      repeat (3) @(negedge clk);
      // R1 reset state
      check(en == 0, "R1 enable", en, 0);
      check(capture == 0 && count == 0, "R1 counters", capture, 0);
      check(ovf == 0 && irq == 0, "R1 flags", ovf, 0);
      check(mode == 2'b11, "R1 mode", mode, 3);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R2 arming
      pulse_start();
      check(en == 1, "R2 enable", en, 1);
      repeat (10) @(negedge clk);
      check(count == 0 && !irq, "R2 waits", count, 0);

      // vector table: R3, R4, R6 (back-to-back phases without restart)
      cur_hi = 1'b1;
      foreach (VEC[k]) begin
         bit vhi;
         int w;
         vhi = VEC[k][16];
         w = int'(VEC[k][15:0]);
         if (vhi != cur_hi) begin
            pulse_stop();
            sig = ~vhi;
            repeat (4) @(negedge clk);
            write_mode({1'b1, vhi});
            pulse_start();
            cur_hi = vhi;
         end
         repeat (3) @(negedge clk);
         phase(vhi, w, -1, got, cap, ov);
         check(got, vhi ? "R3 irq seen" : "R4 irq seen", got, 1);
         check(cap == w - 1, vhi ? "R3 capture" : "R4 capture", cap, w - 1);
         check(!ov, vhi ? "R3 ovf" : "R4 ovf", ov, 0);
      end

      // back to high phase
      pulse_stop();
      sig = 1'b0;
      repeat (4) @(negedge clk);
      write_mode(2'b11);
      check(mode == 2'b11, "R11 legal write", mode, 3);
      pulse_start();
      repeat (3) @(negedge clk);

      // R6 hold while armed
      phase(1'b1, 20, -1, got, cap, ov);
      repeat (15) @(negedge clk);
      check(count == 20, "R6 hold while armed", count, 20);

      // R8 start while enabled
      phase(1'b1, 50, 25, got, cap, ov);
      check(en == 1, "R8 still enabled", en, 1);
      check(got && cap == 49, "R8 capture", cap, 49);

      // R10 no ticks
      repeat (3) @(negedge clk);
      tick = 1'b0;
      phase(1'b1, 30, -1, got, cap, ov);
      tick = 1'b1;
      check(got && cap == 0, "R10 no tick capture", cap, 0);

      // R11 mode locked while enabled, illegal value ignored
      write_mode(2'b10);
      check(mode == 2'b11, "R11 locked", mode, 3);
      pulse_stop();
      write_mode(2'b01);
      check(mode == 2'b11, "R11 illegal", mode, 3);
      pulse_start();
      repeat (3) @(negedge clk);

      // R7 overflow
      phase(1'b1, 66000, -1, got, cap, ov);
      check(got && cap == 463, "R7 wrapped capture", cap, 463);
      check(ov == 1, "R7 ovf set", ov, 1);

      // R9 stop keeps results, no interrupt
      pulse_stop();
      check(en == 0, "R9 disabled", en, 0);
      repeat (3) @(negedge clk);
      phase(1'b1, 20, -1, got, cap, ov);
      check(!got, "R9 no irq", got, 0);
      check(capture == 463 && ovf == 1, "R9 retained", capture, 463);

      // R7 cleared on next clean measurement
      pulse_start();
      repeat (3) @(negedge clk);
      phase(1'b1, 10, -1, got, cap, ov);
      check(got && cap == 9, "R7 clean capture", cap, 9);
      check(ov == 0, "R7 ovf cleared", ov, 0);

      finish_run();
   end

endmodule